// File: doc/BRIEF.md
# Interleaved Multiphase PWM Timer

This block times the switching pulses of a multiphase buck regulator with up to four phases, named A, B, C and D. One shared counter sets a fixed switching period. Every active phase fires once per period, and the active phases are spread evenly across that period, so their ripple currents partly cancel. A two-bit phase-count select picks two, three or four phases. In two-phase mode the phases are A and C, which sit on opposite sides of the layout.

An external control loop supplies an on-time command for each phase, counted in clock cycles. The block captures a phase's command when that phase's pulse starts. Before use, the command is clamped between a minimum on-time and the maximum duty. A per-phase current-limit flag can cut the present pulse short, but only after the minimum on-time. The next pulse of that phase is not affected. While the enable is low, every drive output is low and the timebase is held at its start.

The duty commands, the flags and the select are plain level inputs and have no handshake. The loop may change them at any time, because the block decides when it samples each one.

Top module: `pwm_interleave`

## Requirements
- R1: While reset is asserted, and after reset until the enable rises, all four drive outputs are low.
- R2: The select is decoded as follows. Code 2'b01 activates phases A and C. Code 2'b00 activates A, B and C. Code 2'b10 activates all four phases, and the unused code 2'b11 behaves like 2'b10. Drive bit 0 is phase A, bit 1 is B, bit 2 is C and bit 3 is D.
- R3: Each active phase starts exactly one pulse per period of PERIOD_CYC clock cycles while the enable stays high.
- R4: Phase A starts at the first clock edge that sees the enable high, which is timebase count 0. With N active phases, the phase in position s of the active list starts at count s*PERIOD_CYC/N.
- R5: A command between MIN_ON_CYC and MAX_ON, inclusive, gives a pulse that is exactly that many cycles long. MAX_ON is PERIOD_CYC*MAX_DUTY_PCT/100.
- R6: A command of zero starts no pulse in that period.
- R7: A command from 1 to MIN_ON_CYC-1 gives a pulse of MIN_ON_CYC cycles.
- R8: A command above MAX_ON gives a pulse of MAX_ON cycles.
- R9: If a phase's limit flag is sampled high at an edge after that phase has been high for at least MIN_ON_CYC cycles, the output goes low at that edge. A flag sampled before then has no effect. The next pulse of the phase follows its own command.
- R10: Once the enable is sampled low, all outputs are low from that edge on, and the timebase restarts from count 0 at the next enable.
- R11: The command is captured at the pulse start. A change while the pulse is high does not alter that pulse's length.
- R12: While the block runs, a new select value takes effect only at the period boundary. A phase outside the active set is never high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| phsel_i | input | 2 | Phase-count select (01: A+C, 00: A+B+C, 10/11: all four) |
| duty_i | input | 4*DW | On-time commands in cycles, phase A in the lowest DW bits |
| ilim_i | input | 4 | Per-phase current-limit flags |
| drive_o | output | 4 | Drive outputs, bit 0 is phase A |

## Verification
The bench targets the edges of the clamp: zero, just below and at the minimum, at the maximum and far above it. A wrong clamp would produce a stray pulse, a runt pulse or a pulse that runs past 75%. Current-limit flags are raised early and late inside pulses. A design that honoured an early flag would break the minimum on-time, and one that carried the flag into the next period would shorten a pulse that is still healthy. The select and the enable are changed mid-period and mid-pulse. These cases catch offsets taken from the wrong phase count, phases left high after being dropped from the set, mode switches that land part-way through a period, and a timebase that does not restart at count 0.

// File: rtl/pwm_interleave_pkg.sv
package pwm_interleave_pkg;

  localparam int unsigned NUM_PH = 4;

  typedef enum logic [1:0] {
    SEL_THREE = 2'b00,
    SEL_TWO   = 2'b01,
    SEL_FOUR  = 2'b10,
    SEL_SPARE = 2'b11
  } phsel_e;

  // active set: bit 0 = A ... bit 3 = D
  function automatic logic [NUM_PH-1:0] active_mask(input logic [1:0] sel);
    case (sel)
      SEL_TWO:   active_mask = 4'b0101;
      SEL_THREE: active_mask = 4'b0111;
      default:   active_mask = 4'b1111;
    endcase
  endfunction

  function automatic int unsigned phase_count(input logic [1:0] sel);
    case (sel)
      SEL_TWO:   phase_count = 2;
      SEL_THREE: phase_count = 3;
      default:   phase_count = 4;
    endcase
  endfunction

  // start count of a phase inside the period; meaningful for active phases only
  function automatic int unsigned phase_offset(input logic [1:0] sel,
                                               input int unsigned ph,
                                               input int unsigned period);
    int unsigned pos;
    if (sel == SEL_TWO) pos = (ph == 2) ? 1 : 0;
    else                pos = ph;
    phase_offset = pos * period / phase_count(sel);
  endfunction

endpackage

// File: rtl/pwm_interleave_timebase.sv
module pwm_interleave_timebase #(
  parameter int unsigned PERIOD_CYC = 336,
  localparam int unsigned CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] cnt_o,
  output logic [1:0]    sel_q_o,
  output logic [1:0]    sel_nxt_o
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    sel_q;
  logic          wrap;

  assign wrap      = (cnt_q == LAST);
  assign sel_nxt_o = (!en_i || wrap) ? sel_i : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 2'b10;
    end else begin
      sel_q <= sel_nxt_o;
      if (!en_i || wrap) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign sel_q_o = sel_q;

  // R3: the count never leaves the period
  p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R12: the latched select only moves at a boundary while running
  p_sel_at_boundary_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && $past(cnt_q) != LAST) |-> $stable(sel_q));

  // R10: a disabled timebase sits at zero
  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0);

endmodule

// File: rtl/pwm_interleave_slot.sv
module pwm_interleave_slot #(
  parameter int unsigned DW         = 9,
  parameter int unsigned MIN_ON_CYC = 12,
  parameter int unsigned MAX_ON     = 252
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          start_i,
  input  logic [DW-1:0] duty_i,
  input  logic          ilim_i,
  output logic          drv_o
);

  localparam logic [DW-1:0] MIN_V = DW'(MIN_ON_CYC);
  localparam logic [DW-1:0] MAX_V = DW'(MAX_ON);

  logic          drv_q;
  logic [DW-1:0] len_q, on_q, len_c;

  always_comb begin
    if (duty_i == '0)        len_c = '0;
    else if (duty_i < MIN_V) len_c = MIN_V;
    else if (duty_i > MAX_V) len_c = MAX_V;
    else                     len_c = duty_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      len_q <= '0;
      on_q  <= '0;
    end else if (!active_i) begin
      drv_q <= 1'b0;
    end else if (start_i) begin
      drv_q <= (len_c != '0);
      len_q <= len_c;
      on_q  <= DW'(1);
    end else if (drv_q) begin
      if (on_q == len_q || (ilim_i && on_q >= MIN_V)) drv_q <= 1'b0;
      else                                           on_q  <= on_q + 1'b1;
    end
  end

  assign drv_o = drv_q;

  // R7: a pulse shorter than the minimum only ends through deactivation
  p_min_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q && on_q < MIN_V && active_i && !start_i) |=> drv_q);

  // R8: the high time never exceeds the maximum duty
  p_max_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> on_q <= MAX_V);

  // R4: a pulse only begins on a start request
  p_rise_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> $past(start_i));

endmodule

// File: rtl/pwm_interleave.sv
module pwm_interleave
  import pwm_interleave_pkg::*;
#(
  parameter int unsigned PERIOD_CYC   = 336,
  parameter int unsigned MIN_ON_CYC   = 12,
  parameter int unsigned MAX_DUTY_PCT = 75,
  localparam int unsigned MAX_ON = PERIOD_CYC * MAX_DUTY_PCT / 100,
  localparam int unsigned DW     = $clog2(PERIOD_CYC + 1),
  localparam int unsigned CW     = $clog2(PERIOD_CYC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [1:0]         phsel_i,
  input  logic [4*DW-1:0]    duty_i,
  input  logic [3:0]         ilim_i,
  output logic [3:0]         drive_o
);

  logic [CW-1:0]     cnt;
  logic [1:0]        sel_q, sel_nxt;
  logic [NUM_PH-1:0] act_nxt;

  pwm_interleave_timebase #(.PERIOD_CYC(PERIOD_CYC)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .sel_i     (phsel_i),
    .cnt_o     (cnt),
    .sel_q_o   (sel_q),
    .sel_nxt_o (sel_nxt)
  );

  assign act_nxt = active_mask(sel_nxt);

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    logic act, start;
    assign act   = en_i && act_nxt[k];
    assign start = act && (cnt == CW'(phase_offset(sel_q, k, PERIOD_CYC)));

    pwm_interleave_slot #(
      .DW(DW), .MIN_ON_CYC(MIN_ON_CYC), .MAX_ON(MAX_ON)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (act),
      .start_i  (start),
      .duty_i   (duty_i[k*DW +: DW]),
      .ilim_i   (ilim_i[k]),
      .drv_o    (drive_o[k])
    );
  end

  // R12: phases outside the latched set stay low
  p_inactive_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o & ~active_mask(sel_q)) == '0);

  // R10: a low enable clears every output at the next edge
  p_disabled_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> drive_o == '0);

  // R2: two-phase mode never drives B or D
  p_two_phase_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b01) |-> (drive_o[1] == 1'b0 && drive_o[3] == 1'b0));

endmodule

// File: tb/pwm_interleave_bench.sv
module pwm_interleave_bench;
  localparam int P = 336, MINON = 12, MAXON = 252, DW = 9;

  logic clk = 0, rst_n = 0, en = 0;
  logic [1:0] sel = 2'b10;
  logic [4*DW-1:0] duty = '0;
  logic [3:0] ilim = '0;
  logic [3:0] drv;

  always #5 clk = ~clk;

  pwm_interleave u_pwm_interleave (
    .clk(clk), .rst_n(rst_n), .en_i(en), .phsel_i(sel),
    .duty_i(duty), .ilim_i(ilim), .drive_o(drv)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  function automatic bit in_set(logic [1:0] s, int k);
    case (s)
      2'b01:   return (k == 0 || k == 2);
      2'b00:   return (k <= 2);
      default: return 1;
    endcase
  endfunction

  function automatic int start_at(logic [1:0] s, int k);
    case (s)
      2'b01:   return (k == 0) ? 0 : P / 2;
      2'b00:   return k * P / 3;
      default: return k * P / 4;
    endcase
  endfunction

  function automatic int clamp_len(int d);
    if (d == 0) return 0;
    if (d < MINON) return MINON;
    if (d > MAXON) return MAXON;
    return d;
  endfunction

  // reference model built from the requirements
  int m_t;
  logic [1:0] m_md;
  logic [3:0] m_hi;
  int m_len [4];
  int m_on  [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_md = 2'b10; m_hi = '0;
    end else begin
      logic [1:0] nmd;
      nmd = (!en || m_t == P - 1) ? sel : m_md;
      for (int k = 0; k < 4; k++) begin
        bit act;
        act = en && in_set(nmd, k);
        if (!act) m_hi[k] = 0;
        else if (m_t == start_at(m_md, k)) begin
          m_len[k] = clamp_len(int'(duty[k*DW +: DW]));
          m_hi[k] = (m_len[k] > 0);
          m_on[k] = 1;
        end else if (m_hi[k]) begin
          if (m_on[k] == m_len[k] || (ilim[k] && m_on[k] >= MINON)) m_hi[k] = 0;
          else m_on[k]++;
        end
      end
      m_t = (!en || m_t == P - 1) ? 0 : m_t + 1;
      m_md = nmd;
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      checks++;
      if (drv !== m_hi) begin
        errors++;
        $display("FAIL %s: drive=%b expected=%b (count %0d)", req, drv, m_hi, m_t);
      end
    end
  endtask

  task automatic set_all(int v);
    for (int k = 0; k < 4; k++) duty[k*DW +: DW] = DW'(v);
  endtask

  task automatic rnd_duty(int lo, int hi);
    for (int k = 0; k < 4; k++) duty[k*DW +: DW] = DW'(lo + $urandom_range(hi - lo));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    req = "R1"; tick(4); rst_n = 1; tick(6);

    req = "R2"; sel = 2'b01; set_all(100); en = 1; tick(2 * P);
    en = 0; tick(3); sel = 2'b00; en = 1; tick(2 * P);
    en = 0; tick(3); sel = 2'b11; en = 1; tick(2 * P);

    req = "R3"; en = 0; tick(2); sel = 2'b10; set_all(200); en = 1; tick(3 * P);

    req = "R4"; duty = {DW'(40), DW'(30), DW'(20), DW'(10)};
    en = 0; tick(1); sel = 2'b00; en = 1; tick(2 * P);

    req = "R5"; sel = 2'b10;
    repeat (4) begin rnd_duty(MINON, MAXON); tick(P); end
    set_all(MINON); tick(P); set_all(MAXON); tick(P);

    req = "R6"; duty = {DW'(0), DW'(90), DW'(0), DW'(90)}; tick(2 * P);

    req = "R7"; set_all(1); tick(P); set_all(MINON - 1); tick(P);

    req = "R8"; set_all(MAXON + 1); tick(P); set_all(511); tick(P);

    req = "R9"; set_all(200);
    for (int c = 0; c < 4 * P; c++) begin
      ilim = ($urandom_range(30) == 0) ? 4'($urandom) : 4'b0000;
      tick(1);
    end
    ilim = '0; tick(P);

    req = "R10";
    for (int c = 0; c < 4 * P; c++) begin
      if ($urandom_range(150) == 0) en = ~en;
      tick(1);
    end
    en = 1; tick(P);

    req = "R11";
    for (int c = 0; c < 3 * P; c++) begin
      if ($urandom_range(7) == 0) rnd_duty(0, 400);
      tick(1);
    end

    req = "R12";
    for (int c = 0; c < 6 * P; c++) begin
      if ($urandom_range(100) == 0) sel = 2'($urandom);
      tick(1);
    end

    req = "R9";
    for (int c = 0; c < 6 * P; c++) begin
      if ($urandom_range(60) == 0) sel = 2'($urandom);
      if ($urandom_range(20) == 0) rnd_duty(0, 300);
      ilim = ($urandom_range(25) == 0) ? 4'($urandom) : 4'b0000;
      if ($urandom_range(400) == 0) en = ~en;
      tick(1);
    end

    req = "R10"; en = 0; ilim = '0; tick(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule